// File: doc/BRIEF.md
# Infrared SIR Pulse Codec with Echo Blanking

This block sits between one UART channel's serial lines and an infrared transceiver. When infrared mode is on, each zero bit leaving the UART becomes a short high pulse in the middle of its bit cell. A one bit produces no pulse, so the optical transmit pin rests low. In the other direction, each pulse seen on the optical receive pin is stretched into a zero bit one bit period long for the UART receiver. With no pulses the UART sees a steady one. When infrared mode is off, both serial paths pass straight through without change.

The mode bit is preset from a board strap input on the first clock after reset is released. Software may change it later through a one-cycle write strobe. While infrared mode is on, the optical receive path is blanked whenever the transmitter drives a zero bit, and for one further bit time after that. This keeps the transmitter's own light, reflected or coupled back, out of the receiver. All bit timing comes from a 16x oversampling enable shared with the UART. The UART is expected to change its serial output only on clocks where that enable is high.

Top module: `ir_sir_codec`

## Requirements
- R1: While reset is held, and until the first clock after its synchronized release, the mode is off (passthrough). On that clock the mode takes the value of `ir_strap`. Later changes of `ir_strap` have no effect until the next reset.
- R2: A clock with `mode_we` high loads `mode_wdata` into the mode (1 = infrared, 0 = passthrough). The new mode governs the pins from the following clock.
- R3: In infrared mode with the default 16 ticks per bit and a 3-tick pulse, a UART zero bit drives `ir_txd` high for ticks 6, 7 and 8 of the bit. Tick 0 is the first enabled tick after `uart_txd` changes, and later bit cells of a run follow every 16 ticks. Outside those ticks `ir_txd` is low, and it changes only on clocks that follow an enabled tick.
- R4: In infrared mode a UART one bit, including the idle line, leaves `ir_txd` at 0.
- R5: In infrared mode, outside blanking, a rising level on `ir_rxd` drives `uart_rxd` to 0 after the third rising clock edge. It stays 0 until the sixteenth enabled tick after that point. A pulse that arrives while this is in progress restarts the count.
- R6: In infrared mode, with `ir_rxd` held at its idle level 0, `uart_rxd` stays at 1.
- R7: In infrared mode, blanking holds `uart_rxd` at 1 and discards any pulse on `ir_rxd`. Blanking is active while `uart_txd` is 0 and for 16 enabled ticks after the last tick on which `uart_txd` was 0.
- R8: With the mode off, `ir_txd` equals `uart_txd` and `uart_rxd` equals `ir_rxd` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud16_en | input | 1 | One-clock enable at 16 times the bit rate |
| ir_strap | input | 1 | Board strap giving the mode after reset |
| mode_we | input | 1 | Write strobe for the mode bit |
| mode_wdata | input | 1 | Mode value to write (1 = infrared) |
| uart_txd | input | 1 | Serial data from the UART transmitter |
| ir_rxd | input | 1 | Optical receiver output, active-high pulses |
| ir_txd | output | 1 | Optical transmitter drive |
| uart_rxd | output | 1 | Recovered serial data for the UART receiver |

## Verification
The assertions assume that `uart_txd` changes only together with an enabled tick and that each bit lasts exactly 16 ticks. They also assume that an incoming pulse is wider than two clocks, so that the synchronizer catches it, and that an echo pulse ends before blanking does. The bench drives the transmit line one tick slot at a time, with a tick on every second clock. It loops `ir_txd` back to `ir_rxd` during the transmit sweep and keeps each injected receive pulse three ticks wide, centred like a real one. Mode changes are made only while ticks are idle, so the pulse register does not change at the same moment.

// File: rtl/sir_pkg.sv
package sir_pkg;

  localparam int unsigned SIR_OVS_DEFAULT   = 16;
  localparam int unsigned SIR_PULSE_DEFAULT = 3;
  localparam int unsigned SIR_SYNC_DEFAULT  = 2;

  // first tick of a pulse centred in a cell of ovs ticks
  function automatic int unsigned centred_start(input int unsigned ovs, input int unsigned len);
    return (ovs - len) / 2;
  endfunction

endpackage

// File: rtl/sir_reset_sync.sv
module sir_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/sir_tx_shaper.sv
module sir_tx_shaper #(
  parameter int unsigned OVS         = 16,
  parameter int unsigned PULSE_TICKS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ser_i,
  output logic pulse_o
);

  localparam int unsigned PW    = $clog2(OVS);
  localparam int unsigned P_BEG = sir_pkg::centred_start(OVS, PULSE_TICKS);
  localparam int unsigned P_END = P_BEG + PULSE_TICKS;

  logic [PW-1:0] phase_q, phase_d, phase_now;
  logic          last_q, last_d;
  logic          pulse_q, pulse_d;
  logic          in_window;

  always_comb begin
    phase_now = (ser_i != last_q) ? '0 : phase_q;
    in_window = ({1'b0, phase_now} >= (PW+1)'(P_BEG)) &&
                ({1'b0, phase_now} <  (PW+1)'(P_END));
    phase_d   = phase_q;
    last_d    = last_q;
    pulse_d   = pulse_q;
    if (tick_i) begin
      last_d  = ser_i;
      phase_d = (phase_now == PW'(OVS - 1)) ? '0 : phase_now + 1'b1;
      pulse_d = !ser_i && in_window;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      last_q  <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      last_q  <= last_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

  AST_PULSE_ONLY_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(pulse_o)); // R3

  AST_NO_PULSE_FOR_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && ser_i) |=> !pulse_o); // R4

endmodule

// File: rtl/sir_echo_blank.sv
module sir_echo_blank #(
  parameter int unsigned OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic mode_i,
  input  logic ser_i,
  output logic blank_o
);

  localparam int unsigned HW = $clog2(OVS + 1);

  logic [HW-1:0] hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (tick_i) begin
      if (!ser_i) begin
        hold_d = HW'(OVS);
      end else if (hold_q != '0) begin
        hold_d = hold_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
    end else begin
      hold_q <= hold_d;
    end
  end

  assign blank_o = mode_i && (!ser_i || (hold_q != '0));

  AST_BLANK_OUTLASTS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && tick_i && !ser_i) |=> (blank_o || !mode_i)); // R7

endmodule

// File: rtl/sir_rx_stretch.sv
module sir_rx_stretch #(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic kill_i,
  input  logic pin_i,
  output logic bit_o
);

  localparam int unsigned CW = $clog2(OVS + 1);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   gated, rise;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin_i};
    gated  = sync_q[SYNC_STAGES-1] && !kill_i;
    rise   = gated && !prev_q;
    prev_d = gated;
    cnt_d  = cnt_q;
    if (kill_i) begin
      cnt_d = '0;
    end else if (rise) begin
      cnt_d = CW'(OVS);
    end else if (tick_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
      cnt_q  <= cnt_d;
    end
  end

  assign bit_o = (cnt_q == '0) || kill_i;

  AST_STRETCH_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && !kill_i) |=> (cnt_q == CW'(OVS))); // R5

  AST_COUNT_WAITS_FOR_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !rise && !kill_i) |=> $stable(cnt_q)); // R5

  AST_IDLE_STAYS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !rise) |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/ir_sir_codec.sv
module ir_sir_codec #(
  parameter int unsigned OVS         = sir_pkg::SIR_OVS_DEFAULT,
  parameter int unsigned PULSE_TICKS = sir_pkg::SIR_PULSE_DEFAULT,
  parameter int unsigned SYNC_STAGES = sir_pkg::SIR_SYNC_DEFAULT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic baud16_en,
  input  logic ir_strap,
  input  logic mode_we,
  input  logic mode_wdata,
  input  logic uart_txd,
  input  logic ir_rxd,
  output logic ir_txd,
  output logic uart_rxd
);

  logic rst_sync_n;
  logic boot_q, boot_d;
  logic ir_mode_q, ir_mode_d;
  logic tx_pulse;
  logic blank;
  logic rx_kill;
  logic rx_bit;

  sir_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i  (clk),
    .arst_ni(rst_n),
    .rst_no (rst_sync_n)
  );

  // mode register: write strobe wins, otherwise strap on the first free clock
  always_comb begin
    boot_d    = 1'b0;
    ir_mode_d = ir_mode_q;
    if (mode_we) begin
      ir_mode_d = mode_wdata;
    end else if (boot_q) begin
      ir_mode_d = ir_strap;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      boot_q    <= 1'b1;
      ir_mode_q <= 1'b0;
    end else begin
      boot_q    <= boot_d;
      ir_mode_q <= ir_mode_d;
    end
  end

  sir_tx_shaper #(.OVS(OVS), .PULSE_TICKS(PULSE_TICKS)) u_tx (
    .clk_i  (clk),
    .rst_ni (rst_sync_n),
    .tick_i (baud16_en),
    .ser_i  (uart_txd),
    .pulse_o(tx_pulse)
  );

  sir_echo_blank #(.OVS(OVS)) u_blank (
    .clk_i  (clk),
    .rst_ni (rst_sync_n),
    .tick_i (baud16_en),
    .mode_i (ir_mode_q),
    .ser_i  (uart_txd),
    .blank_o(blank)
  );

  assign rx_kill = blank || !ir_mode_q;

  sir_rx_stretch #(.OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_i (clk),
    .rst_ni(rst_sync_n),
    .tick_i(baud16_en),
    .kill_i(rx_kill),
    .pin_i (ir_rxd),
    .bit_o (rx_bit)
  );

  assign ir_txd   = ir_mode_q ? tx_pulse : uart_txd;
  assign uart_rxd = ir_mode_q ? rx_bit   : ir_rxd;

  AST_STRAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (boot_q && !mode_we) |=> (ir_mode_q == $past(ir_strap))); // R1

  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode_we |=> (ir_mode_q == $past(mode_wdata))); // R2

  AST_IR_TX_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ir_mode_q && $past(ir_mode_q) && $past(baud16_en) && $past(uart_txd)) |-> !ir_txd); // R4

  AST_BLANKED_RX_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ir_mode_q && blank) |-> uart_rxd); // R7

endmodule

// File: tb/ir_sir_codec_bench.sv
module ir_sir_codec_bench;

  logic clk = 1'b0;
  logic rst_n, baud16_en, ir_strap, mode_we, mode_wdata, uart_txd, ir_rxd;
  logic ir_txd, uart_rxd;
  int   checks = 0;
  int   errors = 0;

  always #4 clk = ~clk;

  ir_sir_codec u_ir_sir_codec (
    .clk(clk), .rst_n(rst_n), .baud16_en(baud16_en), .ir_strap(ir_strap),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .uart_txd(uart_txd),
    .ir_rxd(ir_rxd), .ir_txd(ir_txd), .uart_rxd(uart_rxd)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // one tick slot: tick driven with new tx bit, ends at the negedge after the register edge
  task automatic slot(input logic en, input logic txd);
    @(negedge clk);
    baud16_en = en;
    uart_txd  = txd;
    @(negedge clk);
    baud16_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot(1'b1, 1'b1);
  endtask

  task automatic write_mode(input logic v);
    @(negedge clk);
    mode_we = 1'b1; mode_wdata = v;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  // exact pulse-to-zero timing, then release by ticks
  task automatic rx_exact(input string req);
    @(negedge clk); ir_rxd = 1'b1;
    @(negedge clk); check(uart_rxd, 1'b1, req);
    @(negedge clk); check(uart_rxd, 1'b1, req);
    @(negedge clk); check(uart_rxd, 1'b0, req);
    ir_rxd = 1'b0;
    for (int t = 1; t <= 16; t++) begin
      slot(1'b1, 1'b1);
      check(uart_rxd, (t == 16), req);
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0; ir_strap = strap; uart_txd = 1'b1; ir_rxd = 1'b0;
    baud16_en = 1'b0; mode_we = 1'b0; mode_wdata = 1'b0;
    repeat (3) @(negedge clk);
    check(ir_txd, 1'b1, "R1 passthrough in reset");
    ir_rxd = 1'b1; #1;
    check(uart_rxd, 1'b1, "R1 passthrough in reset");
    ir_rxd = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(ir_txd, !strap, "R1 strap captured");
    ir_strap = !strap;
    repeat (5) @(negedge clk);
    check(ir_txd, !strap, "R1 strap change ignored");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [9:0] fr;
    logic       prev;
    do_reset(1'b1);
    check(uart_rxd, 1'b1, "R6 idle");
    idle(20);
    check(uart_rxd, 1'b1, "R6 idle after ticks");
    check(ir_txd, 1'b0, "R4 idle low");

    // all bytes, with optical loopback: R3, R4, R7
    for (int b = 0; b < 256; b++) begin
      fr = {1'b1, 8'(b), 1'b0};
      for (int k = 0; k < 10; k++) begin
        for (int t = 0; t < 16; t++) begin
          slot(1'b1, fr[k]);
          check(ir_txd, (!fr[k] && t >= 6 && t <= 8), fr[k] ? "R4 one bit" : "R3 zero pulse");
          check(uart_rxd, 1'b1, "R7 echo blanked");
          ir_rxd = ir_txd;
        end
      end
    end
    ir_rxd = 1'b0;
    idle(20);

    rx_exact("R5 stretch timing");

    // received frames from centred pulses: R5, R6
    for (int b = 0; b < 256; b += 9) begin
      fr = {1'b1, 8'(b), 1'b0};
      prev = 1'b1;
      for (int k = 0; k < 10; k++) begin
        for (int t = 0; t < 16; t++) begin
          if (t == 6 && !fr[k]) ir_rxd = 1'b1;
          if (t == 9) ir_rxd = 1'b0;
          slot(1'b1, 1'b1);
          if (t == 3)  check(uart_rxd, prev, prev ? "R6 one held" : "R5 zero held");
          if (t == 15) check(uart_rxd, fr[k], fr[k] ? "R6 one bit" : "R5 zero bit");
        end
        prev = fr[k];
      end
    end
    idle(20);

    // blanking during and after a transmitted zero bit: R7
    for (int t = 0; t < 16; t++) begin
      if (t == 3) ir_rxd = 1'b1;
      if (t == 6) ir_rxd = 1'b0;
      slot(1'b1, 1'b0);
      check(uart_rxd, 1'b1, "R7 blank during zero");
    end
    for (int t = 0; t < 16; t++) begin
      if (t == 5) ir_rxd = 1'b1;
      if (t == 8) ir_rxd = 1'b0;
      slot(1'b1, 1'b1);
      check(uart_rxd, 1'b1, "R7 blank extension");
    end
    idle(4);
    rx_exact("R7 blank released");

    // passthrough after a mode write: R2, R8
    write_mode(1'b0);
    for (int a = 0; a < 2; a++) begin
      for (int r = 0; r < 2; r++) begin
        @(negedge clk); uart_txd = 1'(a); ir_rxd = 1'(r); #1;
        check(ir_txd, 1'(a), "R8 tx passthrough");
        check(uart_rxd, 1'(r), "R8 rx passthrough");
      end
    end
    @(negedge clk); uart_txd = 1'b1; ir_rxd = 1'b0;
    write_mode(1'b1);
    check(ir_txd, 1'b0, "R2 infrared after write");
    check(uart_rxd, 1'b1, "R2 infrared rx idle");
    write_mode(1'b0);
    check(ir_txd, 1'b1, "R2 passthrough after write");

    do_reset(1'b0);
    check(uart_rxd, 1'b0, "R8 rx follows pin after strap 0");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule